// File: doc/BRIEF.md
# Asynchronous SRAM Write-Cycle Timing Monitor

This block watches the write side of an asynchronous static-RAM interface. A fast monitor clock samples the two active-low strobes (chip select and write enable), the address bus and the data bus. From these samples the block rebuilds each write window, which is the span in which both strobes are low together. It measures the timing intervals around that window in monitor-clock samples and compares each one with a minimum given as a parameter. A measured value strictly below its minimum is a violation.

Each rule has its own flag. A flag stays set until the clear input is pulsed. A 3-bit code keeps the first rule that was broken. When a write window closes and none of its rules was broken, the block increments a write counter and latches the address and data that were on the bus during the last active sample, so that a scoreboard can compare them. Thresholds are in monitor-clock cycles, and every interval counter saturates at its maximum value.

Top module: `sram_wr_monitor`

## Requirements
- R1: A window is active in each sample where csN and weN are both 0. It ends at the first later sample where either strobe is 1. If the window broke none of the rules R2 to R6, then after the clock edge of that end sample writeCount has risen by 1 (modulo 2^WCNT_W), and lastAddr/lastData hold the addr/data of the window's last active sample.
- R2: If a window has fewer than T_WP active samples, errFlags bit 0 is set.
- R3: If addr differs from its previous sample in a sample that is active and follows an active sample, errFlags bit 1 is set. A change in the first active sample, or in the end sample, is legal.
- R4: If, at the end of a window, fewer than T_AW samples have passed from the last address change up to and including the last active sample, errFlags bit 2 is set.
- R5: If, at the end of a window, fewer than T_CW samples of csN low come before the end sample, errFlags bit 3 is set.
- R6: If, at the end of a window, fewer than T_DW samples have passed from the last data change up to and including the last active sample, errFlags bit 4 is set.
- R7: If an address change follows at least one ended window, and fewer than T_WC samples have passed since the previous address change, errFlags bit 5 is set.
- R8: Flags stay set until a sample with clrErr = 1. That sample clears them, except for violations detected in that same sample, which are kept.
- R9: errCode is 0 while no flag is set. Otherwise it holds (index of the first flag set) + 1. If several flags are set in one sample, the lowest index wins. Later violations do not change errCode until a clear.
- R10: A window that broke any of R2 to R6 leaves writeCount, lastAddr and lastData unchanged.
- R11: Interval counters saturate at 2^CNT_W-1 instead of wrapping. An address held longer than that never appears short.
- R12: After reset, errFlags, errCode, writeCount, lastAddr and lastData are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| clrErr | input | 1 | Clears the sticky flags and the code |
| csN | input | 1 | Sampled chip select, active low |
| weN | input | 1 | Sampled write enable, active low |
| addr | input | ADDR_W | Sampled address bus |
| data | input | DATA_W | Sampled data bus |
| errFlags | output | 6 | Sticky per-rule violation flags |
| errCode | output | 3 | First violation code |
| writeCount | output | WCNT_W | Count of clean writes |
| lastAddr | output | ADDR_W | Address of the last clean write |
| lastData | output | DATA_W | Data of the last clean write |

## Verification
The embedded assertions check on every cycle that the flags never drop without a clear, that the code never moves once set, that the code and the flags agree, that an address move inside a window is flagged, that the counters never wrap, and that the write counter advances only by single steps. Only the directed scenarios can show that each interval is measured to the exact sample. They put each measurement exactly at its threshold and one below it, and they check which flag combination and which code result from a given strobe pattern. They also check that a faulty window leaves the captured address and data alone, and that an address held longer than the counter range does not alias to a short hold.

// File: rtl/sram_wr_mon_pkg.sv
package sram_wr_mon_pkg;

  localparam int NUM_RULES = 6;

  // flag bit positions; errCode = index + 1
  localparam int IDX_PULSE   = 0;
  localparam int IDX_ADDRMOV = 1;
  localparam int IDX_AVALID  = 2;
  localparam int IDX_CSEND   = 3;
  localparam int IDX_DOVL    = 4;
  localparam int IDX_CYCLE   = 5;

  typedef struct packed {
    logic activeNow;
    logic endNow;
    logic captureEn;
  } ctrlStrobe_t;

endpackage

// File: rtl/sram_wr_mon_satcnt.sv
module sram_wr_mon_satcnt #(
  parameter int W = 8,
  parameter bit RST_FULL = 1'b0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         load,
  input  logic [W-1:0] loadVal,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rstN)               count <= RST_FULL ? MAXV : '0;
    else if (load)           count <= loadVal;
    else if (count != MAXV)  count <= count + 1'b1;
  end

  // R11
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!load && count == MAXV) |=> count == MAXV);

  // R11
  monotonic_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!load) |=> count >= $past(count));

endmodule

// File: rtl/sram_wr_mon_dp.sv
module sram_wr_mon_dp
  import sram_wr_mon_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8,
  parameter int WCNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  ctrlStrobe_t       strb,
  output logic              addrChg,
  output logic [CNT_W-1:0]  activeCnt,
  output logic [CNT_W-1:0]  csHeld,
  output logic [CNT_W-1:0]  addrHeld,
  output logic [CNT_W-1:0]  dataHeld,
  output logic [WCNT_W-1:0] writeCount,
  output logic [ADDR_W-1:0] lastAddr,
  output logic [DATA_W-1:0] lastData
);
  localparam int NCNT = 4;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [ADDR_W-1:0] addrPrev;
  logic [DATA_W-1:0] dataPrev;
  logic              dataChg;
  logic [NCNT-1:0]             cntLoad;
  logic [NCNT-1:0][CNT_W-1:0]  cntVal;
  logic [NCNT-1:0][CNT_W-1:0]  cntOut;

  assign addrChg = (addr != addrPrev);
  assign dataChg = (data != dataPrev);

  // 0: active samples, 1: cs-low samples, 2: address age, 3: data age
  assign cntLoad = {dataChg, addrChg, csN, !strb.activeNow};
  assign cntVal  = {ONE, ONE, {CNT_W{1'b0}}, {CNT_W{1'b0}}};

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    sram_wr_mon_satcnt #(.W(CNT_W), .RST_FULL(g >= 2)) u_cnt (
      .clk    (clk),
      .rstN   (rstN),
      .load   (cntLoad[g]),
      .loadVal(cntVal[g]),
      .count  (cntOut[g])
    );
  end

  assign activeCnt = cntOut[0];
  assign csHeld    = cntOut[1];
  assign addrHeld  = cntOut[2];
  assign dataHeld  = cntOut[3];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrPrev   <= '0;
      dataPrev   <= '0;
      writeCount <= '0;
      lastAddr   <= '0;
      lastData   <= '0;
    end else begin
      addrPrev <= addr;
      dataPrev <= data;
      if (strb.captureEn) begin
        writeCount <= writeCount + 1'b1;
        lastAddr   <= addrPrev;
        lastData   <= dataPrev;
      end
    end
  end

  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.captureEn |=> writeCount == WCNT_W'($past(writeCount) + 1'b1));

  // R10
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.captureEn |=> ($stable(writeCount) && $stable(lastAddr) && $stable(lastData)));

endmodule

// File: rtl/sram_wr_mon_ctrl.sv
module sram_wr_mon_ctrl
  import sram_wr_mon_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int T_WC  = 15,
  parameter int T_AW  = 10,
  parameter int T_CW  = 10,
  parameter int T_WP  = 8,
  parameter int T_DW  = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 clrErr,
  input  logic                 csN,
  input  logic                 weN,
  input  logic                 addrChg,
  input  logic [CNT_W-1:0]     activeCnt,
  input  logic [CNT_W-1:0]     csHeld,
  input  logic [CNT_W-1:0]     addrHeld,
  input  logic [CNT_W-1:0]     dataHeld,
  output ctrlStrobe_t          strb,
  output logic [NUM_RULES-1:0] errFlags,
  output logic [2:0]           errCode
);
  localparam logic [CNT_W-1:0] TH_WC = CNT_W'(T_WC);
  localparam logic [CNT_W-1:0] TH_AW = CNT_W'(T_AW);
  localparam logic [CNT_W-1:0] TH_CW = CNT_W'(T_CW);
  localparam logic [CNT_W-1:0] TH_WP = CNT_W'(T_WP);
  localparam logic [CNT_W-1:0] TH_DW = CNT_W'(T_DW);

  logic activeNow, activePrev, endNow;
  logic windowBad, wroteSince;
  logic [NUM_RULES-1:0] viol;
  logic [2:0] violCode;

  assign activeNow = !csN && !weN;
  assign endNow    = activePrev && !activeNow;

  always_comb begin
    viol = '0;
    viol[IDX_PULSE]   = endNow && (activeCnt < TH_WP);
    viol[IDX_ADDRMOV] = activeNow && activePrev && addrChg;
    viol[IDX_AVALID]  = endNow && (addrHeld < TH_AW);
    viol[IDX_CSEND]   = endNow && (csHeld < TH_CW);
    viol[IDX_DOVL]    = endNow && (dataHeld < TH_DW);
    viol[IDX_CYCLE]   = addrChg && (wroteSince || endNow) && (addrHeld < TH_WC);
  end

  always_comb begin
    violCode = 3'd0;
    for (int i = NUM_RULES - 1; i >= 0; i--)
      if (viol[i]) violCode = 3'(i + 1);
  end

  assign strb.activeNow = activeNow;
  assign strb.endNow    = endNow;
  assign strb.captureEn = endNow && !windowBad &&
                          !(viol[IDX_PULSE] || viol[IDX_AVALID] ||
                            viol[IDX_CSEND] || viol[IDX_DOVL]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activePrev <= 1'b0;
      windowBad  <= 1'b0;
      wroteSince <= 1'b0;
      errFlags   <= '0;
      errCode    <= '0;
    end else begin
      activePrev <= activeNow;
      if (endNow)                 windowBad <= 1'b0;
      else if (viol[IDX_ADDRMOV]) windowBad <= 1'b1;
      wroteSince <= addrChg ? 1'b0 : (wroteSince | endNow);
      errFlags   <= (clrErr ? '0 : errFlags) | viol;
      if (clrErr || errCode == 3'd0) errCode <= violCode;
    end
  end

  // R3
  addr_move_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (activeNow && activePrev && addrChg) |=> errFlags[IDX_ADDRMOV]);

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clrErr |=> ((errFlags & $past(errFlags)) == $past(errFlags)));

  // R9
  code_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clrErr && errCode != 3'd0) |=> $stable(errCode));

  // R9
  code_agree_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errCode == 3'd0) == (errFlags == '0));

endmodule

// File: rtl/sram_wr_monitor.sv
module sram_wr_monitor
  import sram_wr_mon_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8,
  parameter int WCNT_W = 16,
  parameter int T_WC   = 15,
  parameter int T_AW   = 10,
  parameter int T_CW   = 10,
  parameter int T_WP   = 8,
  parameter int T_DW   = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clrErr,
  input  logic              csN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic [5:0]        errFlags,
  output logic [2:0]        errCode,
  output logic [WCNT_W-1:0] writeCount,
  output logic [ADDR_W-1:0] lastAddr,
  output logic [DATA_W-1:0] lastData
);
  ctrlStrobe_t      strb;
  logic             addrChg;
  logic [CNT_W-1:0] activeCnt, csHeld, addrHeld, dataHeld;

  sram_wr_mon_ctrl #(
    .CNT_W(CNT_W), .T_WC(T_WC), .T_AW(T_AW), .T_CW(T_CW), .T_WP(T_WP), .T_DW(T_DW)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .clrErr(clrErr), .csN(csN), .weN(weN),
    .addrChg(addrChg), .activeCnt(activeCnt), .csHeld(csHeld),
    .addrHeld(addrHeld), .dataHeld(dataHeld),
    .strb(strb), .errFlags(errFlags), .errCode(errCode)
  );

  sram_wr_mon_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .WCNT_W(WCNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .csN(csN), .addr(addr), .data(data), .strb(strb),
    .addrChg(addrChg), .activeCnt(activeCnt), .csHeld(csHeld),
    .addrHeld(addrHeld), .dataHeld(dataHeld),
    .writeCount(writeCount), .lastAddr(lastAddr), .lastData(lastData)
  );

endmodule

// File: tb/test_sram_wr_monitor.sv
module test_sram_wr_monitor;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clrErr = 1'b0;
  logic        csN = 1'b1;
  logic        weN = 1'b1;
  logic [15:0] addr = '0;
  logic [15:0] data = '0;
  logic [5:0]  errFlags;
  logic [2:0]  errCode;
  logic [15:0] writeCount;
  logic [15:0] lastAddr;
  logic [15:0] lastData;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [15:0] expCount = '0;
  logic [15:0] expAddr = '0;
  logic [15:0] expData = '0;

  always #5 clk = ~clk;

  sram_wr_monitor i_sram_wr_monitor (
    .clk(clk), .rstN(rstN), .clrErr(clrErr), .csN(csN), .weN(weN),
    .addr(addr), .data(data), .errFlags(errFlags), .errCode(errCode),
    .writeCount(writeCount), .lastAddr(lastAddr), .lastData(lastData)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one sample: drive, then wait past the sampling edge
  task automatic cyc(input logic c, input logic w, input logic [15:0] a, input logic [15:0] d);
    csN = c; weN = w; addr = a; data = d;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b1, addr, data);
  endtask

  task automatic doWrite(input logic [15:0] newA, input logic [15:0] newD,
                         input int addrLead, input int csLead, input int dataLate,
                         input int addrMid, input int len);
    int pre;
    logic [15:0] oldA, oldD, a, d;
    oldA = addr; oldD = data;
    pre = (addrLead > csLead) ? addrLead : csLead;
    for (int i = 0; i < pre; i++) begin
      a = (i >= pre - addrLead) ? newA : oldA;
      d = (dataLate > 0) ? oldD : newD;
      cyc((i >= pre - csLead) ? 1'b0 : 1'b1, 1'b1, a, d);
    end
    for (int i = 0; i < len; i++) begin
      a = (addrMid > 0 && i >= addrMid) ? (newA ^ 16'h1) : newA;
      d = (i < dataLate) ? oldD : newD;
      cyc(1'b0, 1'b0, a, d);
    end
    cyc(1'b1, 1'b1, addr, data);
  endtask

  task automatic expectState(input string req, input logic [5:0] f, input logic [2:0] c);
    chk(req, "errFlags", errFlags, f);
    chk(req, "errCode", errCode, c);
    chk(req, "writeCount", writeCount, expCount);
    chk(req, "lastAddr", lastAddr, expAddr);
    chk(req, "lastData", lastData, expData);
  endtask

  task automatic clearFlags();
    clrErr = 1'b1;
    idle(1);
    clrErr = 1'b0;
    chk("R8", "errFlags after clear", errFlags, 0);
    chk("R9", "errCode after clear", errCode, 0);
  endtask

  task automatic testReset();
    expectState("R12", 6'b0, 3'd0);
  endtask

  task automatic testCleanExact();
    // wp=8, cw=10, aw=10, dw=7: every interval exactly at its minimum
    doWrite(16'h1111, 16'hA001, 2, 2, 1, 0, 8);
    expCount++; expAddr = 16'h1111; expData = 16'hA001;
    expectState("R1", 6'b0, 3'd0);
    idle(20);
  endtask

  task automatic testPulseShort();
    doWrite(16'h2222, 16'hA002, 3, 3, 0, 0, 7);
    expectState("R2", 6'b000001, 3'd1);
    idle(20);
    doWrite(16'h2233, 16'hA003, 3, 3, 0, 0, 8);
    expCount++; expAddr = 16'h2233; expData = 16'hA003;
    expectState("R8", 6'b000001, 3'd1);
    idle(20);
    clearFlags();
    // several rules at one end sample: lowest index gives the code
    doWrite(16'h2244, 16'hA004, 0, 0, 0, 0, 7);
    expectState("R9", 6'b001101, 3'd1);
    idle(20);
    clearFlags();
  endtask

  task automatic testAddrValid();
    doWrite(16'h3333, 16'hA005, 0, 2, 0, 0, 9);
    expectState("R4", 6'b000100, 3'd3);
    idle(20);
    doWrite(16'h3344, 16'hA006, 2, 2, 4, 0, 10);
    expectState("R9", 6'b010100, 3'd3);
    idle(20);
    clearFlags();
  endtask

  task automatic testCsEnd();
    doWrite(16'h4444, 16'hA007, 2, 0, 0, 0, 9);
    expectState("R5", 6'b001000, 3'd4);
    idle(20);
    clearFlags();
  endtask

  task automatic testDataOverlap();
    doWrite(16'h5555, 16'hA008, 2, 2, 4, 0, 10);
    expectState("R6", 6'b010000, 3'd5);
    idle(20);
    clearFlags();
  endtask

  task automatic testAddrMove();
    doWrite(16'h6666, 16'hA009, 2, 2, 0, 5, 10);
    expectState("R3", 6'b000110, 3'd2);
    chk("R10", "lastAddr untouched", lastAddr, expAddr);
    idle(20);
    clearFlags();
  endtask

  task automatic testCycleTime();
    doWrite(16'h7000, 16'hB000, 2, 2, 0, 0, 10);
    expCount++; expAddr = 16'h7000; expData = 16'hB000;
    idle(2);
    // 13 + 2 = 15 samples between changes: legal
    doWrite(16'h7001, 16'hB001, 2, 2, 0, 0, 10);
    expCount++; expAddr = 16'h7001; expData = 16'hB001;
    expectState("R7", 6'b0, 3'd0);
    // 13 samples between changes: too short
    doWrite(16'h7002, 16'hB002, 2, 2, 0, 0, 10);
    expCount++; expAddr = 16'h7002; expData = 16'hB002;
    expectState("R7", 6'b100000, 3'd6);
    idle(20);
    clearFlags();
  endtask

  task automatic testSaturate();
    cyc(1'b1, 1'b1, 16'h8888, 16'hC000);
    idle(247);
    // 260 samples of one address: would read 4 if the counter wrapped
    doWrite(16'h8888, 16'hC000, 2, 2, 0, 0, 10);
    expCount++; expAddr = 16'h8888; expData = 16'hC000;
    expectState("R11", 6'b0, 3'd0);
    idle(20);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testCleanExact();
    testPulseShort();
    testAddrValid();
    testCsEnd();
    testDataOverlap();
    testAddrMove();
    testCycleTime();
    testSaturate();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule